// File: doc/BRIEF.md
# Flash Protected-Range Access Checker

This block sits beside a flash controller and decides, for every requested flash cycle, whether the cycle may proceed. It holds five protection-range registers. Each register defines a window of the 32 MiB flash address space at 4 KiB granularity, together with two independent enables: one that blocks reads and one that blocks writes and erases. A requester presents a 25-bit flash linear address, an access kind and a one-cycle strobe. One clock later the block returns a grant or deny decision and a mask naming every range that matched.

Software sets up the ranges over a small register bus and then sets a lockdown bit. Before lockdown every cycle is granted and the ranges can be changed freely. After lockdown the range registers are frozen, the checking is in force, and only a reset releases the lock. Every denied cycle also sets a sticky violation flag, which software clears by writing 1 to it.

Top module: `flash_prot_checker`

## Requirements
- R1: After reset all range registers read 0, the lock and violation flags are 0 and no response is valid.
- R2: Register bus addresses 0 to 4 select ranges 0 to 4. A range word holds the write/erase enable at bit 31, the upper granule number at bits 28:16, the read enable at bit 15 and the lower granule number at bits 12:0. Bits 30:29 and 14:13 always read 0.
- R3: While the lock flag is 0, every request is granted and its hit mask is 0.
- R4: Address 5 is the control word: bit 0 is the lock flag, bit 1 is the violation flag. Writing 1 to bit 0 sets the lock; writing 0 to it does not clear it, and only reset clears it.
- R5: While locked, writes to addresses 0 to 4 are ignored.
- R6: A range covers the addresses from its lower granule number times 4096 up to its upper granule number times 4096 plus 4095, inclusive at both ends.
- R7: Access kind 0 is a read and is checked against the read enable. Kinds 1 (write), 2 (erase) and 3 (treated like erase) are checked against the write/erase enable.
- R8: The response is valid in exactly the cycle after the request strobe. A locked request is denied when at least one range matches.
- R9: Hit mask bit i is 1 when range i is enabled for the access kind and covers the address. All matching ranges are reported, and the mask is 0 whenever no response is valid.
- R10: Every deny sets the violation flag. Writing 1 to control bit 1 clears it. A deny in the same cycle as a clear leaves the flag set.
- R11: A range whose lower granule number is above its upper granule number matches no address.

Ports table below lists ports in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register bus write strobe |
| cfg_addr | input | 3 | Register bus word address (0-4 ranges, 5 control) |
| cfg_wdata | input | 32 | Register bus write data |
| cfg_rdata | output | 32 | Register bus read data for cfg_addr, combinational |
| req_valid | input | 1 | Flash cycle request strobe |
| req_addr | input | 25 | Flash linear address of the request |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 erase, 3 erase-like |
| resp_valid | output | 1 | Decision valid, one cycle after req_valid |
| resp_deny | output | 1 | 1 when the cycle is blocked |
| resp_hit | output | 5 | Mask of ranges that matched the request |
| violation | output | 1 | Sticky flag, set by any deny |
| locked | output | 1 | Lockdown flag |

## Verification
On every cycle the assertions check that the lock flag never falls, that the range registers hold still while locked, that a response follows each strobe by exactly one cycle, that no deny is issued for a request seen while unlocked, and that a deny always appears together with the violation flag. Whether an address is correctly placed inside or outside a window, the kind-to-enable mapping, the inclusive 4 KiB boundaries, inverted windows, overlapping windows and the clear-versus-deny race are shown only by the bench's sweep. That sweep crosses granule edges at both ends of the address space with every access kind and compares against an arithmetic model.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int GRAN_BITS = 12;
    localparam int LIM_W     = 13;
    localparam int ADDR_W    = GRAN_BITS + LIM_W;
    localparam int WORD_W    = 32;

    localparam int WP_BIT    = 31;
    localparam int UP_LSB    = 16;
    localparam int RP_BIT    = 15;
    localparam int LO_LSB    = 0;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_ERASE = 2'd2,
        KIND_OTHER = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic             wr_en;
        logic [LIM_W-1:0] upper;
        logic             rd_en;
        logic [LIM_W-1:0] lower;
    } range_t;

    function automatic range_t word_to_range(input logic [WORD_W-1:0] w);
        range_t r;
        r.wr_en = w[WP_BIT];
        r.upper = w[UP_LSB +: LIM_W];
        r.rd_en = w[RP_BIT];
        r.lower = w[LO_LSB +: LIM_W];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] range_to_word(input range_t r);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WP_BIT]             = r.wr_en;
        w[UP_LSB +: LIM_W]    = r.upper;
        w[RP_BIT]             = r.rd_en;
        w[LO_LSB +: LIM_W]    = r.lower;
        return w;
    endfunction

    function automatic logic kind_uses_wr_en(input logic [1:0] kind);
        return kind != KIND_READ;
    endfunction

endpackage

// File: rtl/fpc_regfile.sv
module fpc_regfile
    import fpc_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int CFG_AW     = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [WORD_W-1:0]             cfg_wdata,
    output range_t [NUM_RANGES-1:0]       ranges,
    output logic                          locked
);
    localparam int CTRL_IDX = NUM_RANGES;

    logic   lock_q;
    range_t [NUM_RANGES-1:0] rng_q;

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_range
        always_ff @(posedge clk) begin
            if (rst) begin
                rng_q[i] <= '0;
            end else if (cfg_we && !lock_q && cfg_addr == CFG_AW'(i)) begin
                rng_q[i] <= word_to_range(cfg_wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (cfg_we && cfg_addr == CFG_AW'(CTRL_IDX) && cfg_wdata[0]) begin
            lock_q <= 1'b1;
        end
    end

    assign ranges = rng_q;
    assign locked = lock_q;

    // R4: the lock flag only ever rises until the next reset
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R5: nothing on the register bus moves a range once locked
    assert_ranges_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(rng_q));

endmodule

// File: rtl/fpc_range_match.sv
module fpc_range_match
    import fpc_pkg::*;
(
    input  range_t            rng,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        kind,
    output logic              hit
);
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic              enabled;

    always_comb begin
        lo_addr = {rng.lower, {GRAN_BITS{1'b0}}};
        hi_addr = {rng.upper, {GRAN_BITS{1'b1}}};
        enabled = kind_uses_wr_en(kind) ? rng.wr_en : rng.rd_en;
        hit     = enabled && (addr >= lo_addr) && (addr <= hi_addr);
    end

endmodule

// File: rtl/fpc_decide.sv
module fpc_decide #(
    parameter int NUM_RANGES = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  locked,
    input  logic                  req_valid,
    input  logic [NUM_RANGES-1:0] hit_vec,
    input  logic                  clr_viol,
    output logic                  resp_valid,
    output logic                  resp_deny,
    output logic [NUM_RANGES-1:0] resp_hit,
    output logic                  violation
);
    logic                  enforce;
    logic                  deny_d;
    logic [NUM_RANGES-1:0] hit_d;

    always_comb begin
        enforce = req_valid && locked;
        hit_d   = enforce ? hit_vec : '0;
        deny_d  = |hit_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_deny  <= 1'b0;
            resp_hit   <= '0;
            violation  <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_deny  <= deny_d;
            resp_hit   <= hit_d;
            violation  <= deny_d || (violation && !clr_viol);
        end
    end

    // R8: a decision follows each strobe after exactly one cycle
    assert_resp_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    assert_no_spurious_resp_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    // R3: a request seen while unlocked is never denied
    assert_unlocked_grants_R3: assert property (@(posedge clk) disable iff (rst)
        !locked |=> !resp_deny);

    // R9: the hit mask is quiet whenever no response is valid
    assert_hit_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> resp_hit == '0);

    // R10: a deny is always accompanied by the sticky flag
    assert_deny_flags_R10: assert property (@(posedge clk) disable iff (rst)
        resp_deny |-> violation);

endmodule

// File: rtl/flash_prot_checker.sv
module flash_prot_checker
    import fpc_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int CFG_AW     = $clog2(NUM_RANGES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic                  req_valid,
    input  logic [24:0]           req_addr,
    input  logic [1:0]            req_kind,
    output logic                  resp_valid,
    output logic                  resp_deny,
    output logic [NUM_RANGES-1:0] resp_hit,
    output logic                  violation,
    output logic                  locked
);
    localparam int CTRL_IDX = NUM_RANGES;

    range_t [NUM_RANGES-1:0] ranges;
    logic   [NUM_RANGES-1:0] hit_vec;
    logic                    clr_viol;

    fpc_regfile #(
        .NUM_RANGES (NUM_RANGES),
        .CFG_AW     (CFG_AW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ranges    (ranges),
        .locked    (locked)
    );

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_match
        fpc_range_match u_match (
            .rng  (ranges[i]),
            .addr (req_addr),
            .kind (req_kind),
            .hit  (hit_vec[i])
        );
    end

    assign clr_viol = cfg_we && (cfg_addr == CFG_AW'(CTRL_IDX)) && cfg_wdata[1];

    fpc_decide #(
        .NUM_RANGES (NUM_RANGES)
    ) u_decide (
        .clk        (clk),
        .rst        (rst),
        .locked     (locked),
        .req_valid  (req_valid),
        .hit_vec    (hit_vec),
        .clr_viol   (clr_viol),
        .resp_valid (resp_valid),
        .resp_deny  (resp_deny),
        .resp_hit   (resp_hit),
        .violation  (violation)
    );

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_addr == CFG_AW'(i)) cfg_rdata = range_to_word(ranges[i]);
        end
        if (cfg_addr == CFG_AW'(CTRL_IDX)) cfg_rdata = {30'd0, violation, locked};
    end

endmodule

// File: tb/flash_prot_checker_tb.sv
module flash_prot_checker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 5;
    localparam logic [31:0] KEEP_MASK = 32'h9FFF_9FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [24:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        resp_valid;
    logic        resp_deny;
    logic [NR-1:0] resp_hit;
    logic        violation;
    logic        locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [31:0] model [NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prot_checker u_dut (
        .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .req_valid (req_valid),
        .req_addr (req_addr), .req_kind (req_kind), .resp_valid (resp_valid),
        .resp_deny (resp_deny), .resp_hit (resp_hit), .violation (violation),
        .locked (locked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NR-1:0] model_hits(input logic [24:0] a, input logic [1:0] k);
        logic [NR-1:0] h;
        h = '0;
        for (int i = 0; i < NR; i++) begin
            logic en;
            logic [24:0] lo, hi;
            en = (k == 2'd0) ? model[i][15] : model[i][31];
            lo = {model[i][12:0], 12'h000};
            hi = {model[i][28:16], 12'hFFF};
            h[i] = en && a >= lo && a <= hi;
        end
        return h;
    endfunction

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one request, checked the next cycle; lk selects the expected policy
    task automatic request(input logic [24:0] a, input logic [1:0] k, input bit lk, input string tag);
        logic [NR-1:0] eh;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_kind = k;
        eh = lk ? model_hits(a, k) : '0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, {resp_valid, resp_deny, 25'd0, resp_hit}, {1'b1, |eh, 25'd0, eh});
    endtask

    task automatic sweep(input bit lk, input string tag);
        for (int s = 0; s < 96; s++) begin
            logic [12:0] g;
            g = (s < 64) ? 13'(s) : 13'(8160 + s - 64);
            for (int o = 0; o < 2; o++) begin
                for (int k = 0; k < 4; k++) begin
                    request({g, (o == 0) ? 12'h000 : 12'hFFF}, 2'(k), lk, tag);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] raw [NR];
        raw[0] = 32'h8007_0004;   // write/erase block, granules 4..7
        raw[1] = 32'h000A_8006;   // read block, granules 6..10
        raw[2] = 32'h8014_8014;   // both, single granule 20
        raw[3] = 32'h801E_8028;   // inverted: lower 40 above upper 30
        raw[4] = 32'h9FFF_9FF9;   // both, top granules 8185..8191

        do_reset();
        // R1: reset state
        for (int i = 0; i < NR + 1; i++) begin
            cfg_read(3'(i), rd);
            chk("R1 reset register", rd, 32'h0);
        end
        chk("R1 reset response", {31'd0, resp_valid}, 32'd0);

        // R2: program with reserved bits set, read back masked
        for (int i = 0; i < NR; i++) begin
            cfg_write(3'(i), raw[i] | 32'h6000_6000);
            model[i] = raw[i] & KEEP_MASK;
        end
        for (int i = 0; i < NR; i++) begin
            cfg_read(3'(i), rd);
            chk("R2 range readback", rd, model[i]);
        end

        // R3: unlocked, everything granted
        sweep(1'b0, "R3 unlocked grant");
        cfg_read(3'd5, rd);
        chk("R3 no violation while unlocked", rd, 32'd0);

        // R4: writing 0 leaves lock clear, writing 1 sets it, 0 does not clear
        cfg_write(3'd5, 32'd0);
        cfg_read(3'd5, rd);
        chk("R4 lock stays clear", rd, 32'd0);
        cfg_write(3'd5, 32'd1);
        cfg_read(3'd5, rd);
        chk("R4 lock set", rd, 32'd1);
        cfg_write(3'd5, 32'd0);
        cfg_read(3'd5, rd);
        chk("R4 lock not cleared by write", rd, 32'd1);

        // R5: range writes ignored once locked
        cfg_write(3'd0, 32'h0000_0000);
        cfg_write(3'd2, 32'h8FFF_8000);
        cfg_read(3'd0, rd);
        chk("R5 range0 unchanged", rd, model[0]);
        cfg_read(3'd2, rd);
        chk("R5 range2 unchanged", rd, model[2]);
        request(25'h0_5000, 2'd1, 1'b1, "R5 frozen range still blocks");

        // R6 R7 R9 R11: locked sweep against the model
        sweep(1'b1, "R6 R7 R9 R11 locked decision");
        request(25'h0_6800, 2'd2, 1'b1, "R7 erase uses write enable");
        request(25'h0_7FFF, 2'd0, 1'b1, "R9 overlap read");
        request(25'h0_7FFF, 2'd1, 1'b1, "R9 overlap write");
        request(25'h2_3000, 2'd3, 1'b1, "R11 inverted range quiet");

        // R8: no strobe, no response
        @(negedge clk);
        @(negedge clk);
        chk("R8 idle response", {31'd0, resp_valid}, 32'd0);

        // R10: sticky violation, clear, race
        cfg_read(3'd5, rd);
        chk("R10 violation set", rd, 32'd3);
        cfg_write(3'd5, 32'd2);
        cfg_read(3'd5, rd);
        chk("R10 violation cleared", rd, 32'd1);
        request(25'h0_0000, 2'd1, 1'b1, "R10 grant request");
        cfg_read(3'd5, rd);
        chk("R10 grant keeps flag clear", rd, 32'd1);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 25'h1_4000; req_kind = 2'd0;
        cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'd2;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        chk("R10 deny beats clear", {30'd0, resp_deny, violation}, 32'd3);

        // R4: only reset clears the lock
        do_reset();
        cfg_read(3'd5, rd);
        chk("R4 reset clears lock", rd, 32'd0);
        cfg_read(3'd4, rd);
        chk("R1 reset clears range", rd, 32'd0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule